// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative translation cache that sits beside a processor's load/store path. A lookup presents an address-space identifier, a virtual page number and an access kind. One clock later the block reports whether a stored translation matched both the identifier and the page number. On a match it also returns the physical frame number, the entry's protection code and a fault flag when the access kind is not allowed by that code. Because every entry carries its address-space tag, a context switch does not need to empty the cache. Translations that belong to different address spaces can sit side by side.

Translations found elsewhere after a miss are written through a fill port. A fill first reuses an entry that already holds the same identifier and page, then any empty slot, and otherwise the next slot of a round-robin pointer. An entry can be pinned when it is written. Pinned entries are never chosen as victims and survive both flush commands. One command flushes every unpinned entry of a single address space, and another flushes every unpinned entry. A fill that finds no slot it is allowed to use is refused, and the block reports this with a one-cycle error pulse.

Top module: `xlate_cache`

## Requirements
- R1: A lookup request produces exactly one of `lkHit` or `lkMiss` on the following clock cycle. With no request, both are low on the following cycle. After reset the cache is empty, so every lookup misses.
- R2: A hit requires a valid entry whose stored address-space identifier and page number both equal the request. The hit returns that entry's frame number on `lkPfn` and its protection code on `lkPerm`.
- R3: After an accepted fill, a lookup of the same identifier and page hits with the filled frame. A lookup made in the same cycle as the fill sees the contents from before the fill.
- R4: A fill whose identifier and page equal a valid entry overwrites that entry in place and never creates a second copy. This holds even when every entry is pinned.
- R5: A fill that matches no entry goes to the lowest-numbered empty slot. When no slot is empty, it goes to the first unpinned slot at or after a round-robin pointer. The pointer is 0 after reset and moves to the slot after the one replaced.
- R6: A pinned entry is never chosen for replacement.
- R7: Protection codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access kinds are 0 read, 1 write and 2 execute. `lkFault` is raised with a hit when the access is not permitted: read needs code 0 or 1, write needs 1, execute needs 2, and access kind 3 always faults. A miss never faults.
- R8: A flush by identifier invalidates every unpinned entry carrying that identifier. Pinned entries and entries of other identifiers are left intact.
- R9: A flush-all invalidates every unpinned entry. A fill presented in the same cycle as either flush command is dropped.
- R10: When every entry is pinned and a fill matches none of them, the fill is refused and the cache contents are unchanged. `fillErr` is high for the one cycle after the fill and low again after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkAsid | input | ASID_W | Lookup address-space identifier |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkAccess | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lkHit | output | 1 | Lookup hit, one cycle after request |
| lkMiss | output | 1 | Lookup miss, one cycle after request |
| lkPfn | output | PFN_W | Frame number of the hit entry |
| lkPerm | output | 2 | Protection code of the hit entry |
| lkFault | output | 1 | Access not permitted by the hit entry |
| fillValid | input | 1 | Fill request |
| fillAsid | input | ASID_W | Fill address-space identifier |
| fillVpn | input | VPN_W | Fill virtual page number |
| fillPfn | input | PFN_W | Fill frame number |
| fillPerm | input | 2 | Fill protection code |
| fillPin | input | 1 | Pin the filled entry |
| fillErr | output | 1 | Fill refused, one cycle after the fill |
| flushAsidValid | input | 1 | Flush unpinned entries of one identifier |
| flushAsid | input | ASID_W | Identifier to flush |
| flushAllValid | input | 1 | Flush every unpinned entry |

## Verification
The bench builds the cache with four entries, 4-bit identifiers and 8-bit page and frame numbers. With only four slots, a handful of fills fills the cache. This puts the round-robin pointer's wrap, the skipping of pinned slots and the fully pinned refusal within a few cycles of each scenario. The exact victim order can then be predicted by hand. A reset before each scenario returns the pointer to zero so that every eviction sequence starts from a known point.

// File: rtl/xlate_cache_pkg.sv
package xlate_cache_pkg;

  typedef enum logic [1:0] {
    PERM_RO   = 2'd0,
    PERM_RW   = 2'd1,
    PERM_XO   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic clrAsid;
  } ctlStrobe_t;

  function automatic logic accessDenied(logic [1:0] perm, logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = (perm == PERM_RO) || (perm == PERM_RW);
      ACC_WRITE: ok = (perm == PERM_RW);
      ACC_EXEC:  ok = (perm == PERM_XO);
      default:   ok = 1'b0;
    endcase
    return !ok;
  endfunction

endpackage

// File: rtl/xlate_cache_store.sv
module xlate_cache_store
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 4,
  parameter int VPN_W   = 12,
  parameter int PFN_W   = 10,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic [1:0]         fillPerm,
  input  logic               fillPin,
  input  logic [ASID_W-1:0]  flushAsid,
  input  logic               lkValid,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [1:0]         lkAccess,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] pinVec,
  output logic [ENTRIES-1:0] fillMatchVec,
  output logic               lkHit,
  output logic               lkMiss,
  output logic [PFN_W-1:0]   lkPfn,
  output logic [1:0]         lkPerm,
  output logic               lkFault
);

  logic [ASID_W-1:0] tagAsid [ENTRIES];
  logic [VPN_W-1:0]  tagVpn  [ENTRIES];
  logic [PFN_W-1:0]  dataPfn [ENTRIES];
  logic [1:0]        dataPerm[ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  // parallel compare for lookup and for fill
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g]       = validVec[g] && (tagAsid[g] == lkAsid) && (tagVpn[g] == lkVpn);
    assign fillMatchVec[g] = validVec[g] && (tagAsid[g] == fillAsid) && (tagVpn[g] == fillVpn);
  end

  logic             anyHit;
  logic [PFN_W-1:0] selPfn;
  logic [1:0]       selPerm;

  always_comb begin
    anyHit  = |hitVec;
    selPfn  = '0;
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        selPfn  = selPfn | dataPfn[i];
        selPerm = selPerm | dataPerm[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit   <= 1'b0;
      lkMiss  <= 1'b0;
      lkPfn   <= '0;
      lkPerm  <= '0;
      lkFault <= 1'b0;
    end else begin
      lkHit   <= lkValid && anyHit;
      lkMiss  <= lkValid && !anyHit;
      lkPfn   <= anyHit ? selPfn : '0;
      lkPerm  <= anyHit ? selPerm : '0;
      lkFault <= lkValid && anyHit && accessDenied(selPerm, lkAccess);
    end
  end

  // entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      pinVec   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!pinVec[i] && (strobe.clrAll || (strobe.clrAsid && tagAsid[i] == flushAsid))) begin
          validVec[i] <= 1'b0;
        end
      end
      if (strobe.wrEn) begin
        validVec[wrIdx] <= 1'b1;
        pinVec[wrIdx]   <= fillPin;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagAsid[wrIdx]  <= fillAsid;
      tagVpn[wrIdx]   <= fillVpn;
      dataPfn[wrIdx]  <= fillPfn;
      dataPerm[wrIdx] <= fillPerm;
    end
  end

endmodule

// File: rtl/xlate_cache_ctrl.sv
module xlate_cache_ctrl
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushAsidValid,
  input  logic               flushAllValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] pinVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  output ctlStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               fillErr
);

  logic [IDX_W-1:0] rrPtr;
  logic             fillGo;
  logic             hasMatch, hasFree, hasVictim;
  logic [IDX_W-1:0] matchIdx, freeIdx, victimIdx;
  logic             useRr;

  // lowest-index match and lowest-index empty slot
  always_comb begin
    hasMatch = 1'b0;
    hasFree  = 1'b0;
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) begin
        hasMatch = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!validVec[i]) begin
        hasFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // first unpinned slot at or after the round-robin pointer
  always_comb begin
    hasVictim = 1'b0;
    victimIdx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int cand;
      cand = (int'(rrPtr) + k) % ENTRIES;
      if (!hasVictim && !pinVec[cand]) begin
        hasVictim = 1'b1;
        victimIdx = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    fillGo         = fillValid && !flushAllValid && !flushAsidValid;
    strobe.clrAll  = flushAllValid;
    strobe.clrAsid = flushAsidValid;
    useRr          = 1'b0;
    wrIdx          = '0;
    if (hasMatch) begin
      wrIdx = matchIdx;
    end else if (hasFree) begin
      wrIdx = freeIdx;
    end else begin
      wrIdx = victimIdx;
      useRr = hasVictim;
    end
    strobe.wrEn = fillGo && (hasMatch || hasFree || hasVictim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr   <= '0;
      fillErr <= 1'b0;
    end else begin
      fillErr <= fillGo && !hasMatch && !hasFree && !hasVictim;
      if (fillGo && useRr) begin
        rrPtr <= (int'(victimIdx) == ENTRIES - 1) ? '0 : victimIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 4,
  parameter int VPN_W   = 12,
  parameter int PFN_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [1:0]        lkAccess,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [1:0]        lkPerm,
  output logic              lkFault,
  input  logic              fillValid,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [1:0]        fillPerm,
  input  logic              fillPin,
  output logic              fillErr,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid,
  input  logic              flushAllValid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ctlStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] validVec, pinVec, fillMatchVec;

  xlate_cache_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .flushAsidValid(flushAsidValid), .flushAllValid(flushAllValid),
    .validVec(validVec), .pinVec(pinVec), .fillMatchVec(fillMatchVec),
    .strobe(strobe), .wrIdx(wrIdx), .fillErr(fillErr)
  );

  xlate_cache_store #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .fillAsid(fillAsid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillPerm(fillPerm), .fillPin(fillPin), .flushAsid(flushAsid),
    .lkValid(lkValid), .lkAsid(lkAsid), .lkVpn(lkVpn), .lkAccess(lkAccess),
    .validVec(validVec), .pinVec(pinVec), .fillMatchVec(fillMatchVec),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPfn(lkPfn), .lkPerm(lkPerm), .lkFault(lkFault)
  );

endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lkValid,
  input logic [1:0] lkAccess,
  input logic       lkHit,
  input logic       lkMiss,
  input logic       lkFault,
  input logic [1:0] lkPerm,
  input logic       fillValid,
  input logic       flushAsidValid,
  input logic       flushAllValid,
  input logic       fillErr
);

  a_r1_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkMiss));

  a_r1_request_answered: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (lkHit || lkMiss));

  a_r1_no_request_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !(lkHit || lkMiss));

  a_r7_fault_only_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> lkHit);

  a_r7_rw_read_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkAccess == 2'd0) |=> !(lkHit && lkPerm == 2'd1 && lkFault));

  a_r10_err_needs_live_fill: assert property (@(posedge clk) disable iff (!rstN)
    !(fillValid && !flushAsidValid && !flushAllValid) |=> !fillErr);

endmodule

bind xlate_cache xlate_cache_chk i_chk (.*);

// File: tb/test_xlate_cache.sv
module test_xlate_cache;

  localparam int ENTRIES = 4;
  localparam int ASID_W  = 4;
  localparam int VPN_W   = 8;
  localparam int PFN_W   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic [VPN_W-1:0]  lkVpn = '0;
  logic [1:0]        lkAccess = '0;
  logic lkHit, lkMiss, lkFault, fillErr;
  logic [PFN_W-1:0] lkPfn;
  logic [1:0] lkPerm;
  logic fillValid = 1'b0;
  logic [ASID_W-1:0] fillAsid = '0;
  logic [VPN_W-1:0]  fillVpn = '0;
  logic [PFN_W-1:0]  fillPfn = '0;
  logic [1:0]        fillPerm = '0;
  logic fillPin = 1'b0;
  logic flushAsidValid = 1'b0;
  logic [ASID_W-1:0] flushAsid = '0;
  logic flushAllValid = 1'b0;

  int nTests = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  xlate_cache #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_xlate_cache (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkAsid(lkAsid), .lkVpn(lkVpn), .lkAccess(lkAccess),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPfn(lkPfn), .lkPerm(lkPerm), .lkFault(lkFault),
    .fillValid(fillValid), .fillAsid(fillAsid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillPerm(fillPerm), .fillPin(fillPin), .fillErr(fillErr),
    .flushAsidValid(flushAsidValid), .flushAsid(flushAsid), .flushAllValid(flushAllValid)
  );

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one lookup, sample the registered result one cycle later
  task automatic look(int asid, int vpn, int acc, output int hit, output int pfn, output int flt);
    @(negedge clk);
    lkValid = 1'b1; lkAsid = ASID_W'(asid); lkVpn = VPN_W'(vpn); lkAccess = 2'(acc);
    @(negedge clk);
    lkValid = 1'b0;
    hit = lkHit ? 1 : 0;
    pfn = int'(lkPfn);
    flt = lkFault ? 1 : 0;
  endtask

  task automatic fill(int asid, int vpn, int pfn, int perm, int pin, output int err);
    @(negedge clk);
    fillValid = 1'b1; fillAsid = ASID_W'(asid); fillVpn = VPN_W'(vpn);
    fillPfn = PFN_W'(pfn); fillPerm = 2'(perm); fillPin = pin[0];
    @(negedge clk);
    fillValid = 1'b0;
    err = fillErr ? 1 : 0;
  endtask

  task automatic expectHit(string req, int asid, int vpn, int expHit, int expPfn);
    int h, p, f;
    look(asid, vpn, 0, h, p, f);
    check(req, h, expHit);
    if (expHit != 0) check(req, p, expPfn);
  endtask

  task automatic tReset();
    int e;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset hit", int'(lkHit), 0);
    check("R1 reset miss", int'(lkMiss), 0);
    rstN = 1'b1;
    expectHit("R1 empty miss", 1, 8'h10, 0, 0);
    check("R10 reset err", int'(fillErr), 0);
    e = 0;
  endtask

  task automatic tBasic();
    int e, h, p, f;
    doReset();
    // R3: lookup in same cycle as fill sees old contents
    @(negedge clk);
    fillValid = 1'b1; fillAsid = 4'd1; fillVpn = 8'h10; fillPfn = 8'h55; fillPerm = 2'd1; fillPin = 1'b0;
    lkValid = 1'b1; lkAsid = 4'd1; lkVpn = 8'h10; lkAccess = 2'd0;
    @(negedge clk);
    fillValid = 1'b0; lkValid = 1'b0;
    check("R3 same-cycle miss", int'(lkMiss), 1);
    expectHit("R3 hit after fill", 1, 8'h10, 1, 8'h55);
    expectHit("R2 other asid miss", 2, 8'h10, 0, 0);
    expectHit("R2 other page miss", 1, 8'h11, 0, 0);
    fill(2, 8'h10, 8'h77, 0, 0, e);
    expectHit("R2 asid2 own frame", 2, 8'h10, 1, 8'h77);
    expectHit("R2 asid1 own frame", 1, 8'h10, 1, 8'h55);
    look(3, 8'h99, 2, h, p, f);
    check("R7 miss no fault", f, 0);
  endtask

  task automatic tProtect();
    int e, h, p, f;
    doReset();
    fill(1, 8'h20, 8'h01, 0, 0, e);   // read-only
    fill(1, 8'h21, 8'h02, 1, 0, e);   // read-write
    fill(1, 8'h22, 8'h03, 2, 0, e);   // execute-only
    fill(1, 8'h23, 8'h04, 3, 0, e);   // no access
    look(1, 8'h20, 0, h, p, f); check("R7 ro read", f, 0);
    look(1, 8'h20, 1, h, p, f); check("R7 ro write", f, 1);
    look(1, 8'h21, 1, h, p, f); check("R7 rw write", f, 0);
    look(1, 8'h21, 2, h, p, f); check("R7 rw exec", f, 1);
    look(1, 8'h22, 2, h, p, f); check("R7 xo exec", f, 0);
    look(1, 8'h22, 0, h, p, f); check("R7 xo read", f, 1);
    look(1, 8'h23, 0, h, p, f); check("R7 none read", f, 1);
    look(1, 8'h21, 3, h, p, f); check("R7 rsvd access", f, 1);
    check("R7 perm out", int'(lkPerm), 1);
  endtask

  task automatic tRoundRobin();
    int e;
    doReset();
    fill(1, 8'h01, 8'hA1, 1, 0, e);
    fill(1, 8'h02, 8'hA2, 1, 0, e);
    fill(1, 8'h03, 8'hA3, 1, 0, e);
    fill(1, 8'h04, 8'hA4, 1, 0, e);
    expectHit("R5 four fit", 1, 8'h01, 1, 8'hA1);
    expectHit("R5 four fit", 1, 8'h04, 1, 8'hA4);
    fill(1, 8'h05, 8'hA5, 1, 0, e);   // replaces slot 0
    expectHit("R5 slot0 evicted", 1, 8'h01, 0, 0);
    expectHit("R5 slot1 kept", 1, 8'h02, 1, 8'hA2);
    fill(1, 8'h06, 8'hA6, 1, 0, e);   // replaces slot 1
    expectHit("R5 slot1 evicted", 1, 8'h02, 0, 0);
    expectHit("R5 slot2 kept", 1, 8'h03, 1, 8'hA3);
    expectHit("R5 new entry", 1, 8'h06, 1, 8'hA6);
  endtask

  task automatic tPinned();
    int e;
    doReset();
    fill(1, 8'h01, 8'hB1, 1, 1, e);   // pinned slot 0
    fill(1, 8'h02, 8'hB2, 1, 0, e);
    fill(1, 8'h03, 8'hB3, 1, 0, e);
    fill(1, 8'h04, 8'hB4, 1, 0, e);
    fill(1, 8'h05, 8'hB5, 1, 0, e);   // skips slot 0, replaces slot 1
    expectHit("R6 pinned kept", 1, 8'h01, 1, 8'hB1);
    expectHit("R5 slot1 evicted", 1, 8'h02, 0, 0);
    fill(1, 8'h06, 8'hB6, 1, 0, e);   // slot 2
    fill(1, 8'h07, 8'hB7, 1, 0, e);   // slot 3
    fill(1, 8'h08, 8'hB8, 1, 0, e);   // wraps, skips 0, slot 1
    expectHit("R6 pinned after wrap", 1, 8'h01, 1, 8'hB1);
    expectHit("R5 wrap evicted slot1", 1, 8'h05, 0, 0);
    expectHit("R5 slot3 kept", 1, 8'h07, 1, 8'hB7);
  endtask

  task automatic tFlush();
    int e;
    doReset();
    fill(1, 8'h31, 8'hC1, 1, 1, e);
    fill(1, 8'h32, 8'hC2, 1, 0, e);
    fill(2, 8'h33, 8'hC3, 1, 0, e);
    @(negedge clk);
    flushAsidValid = 1'b1; flushAsid = 4'd1;
    @(negedge clk);
    flushAsidValid = 1'b0;
    expectHit("R8 pinned survives", 1, 8'h31, 1, 8'hC1);
    expectHit("R8 asid1 flushed", 1, 8'h32, 0, 0);
    expectHit("R8 asid2 kept", 2, 8'h33, 1, 8'hC3);
    @(negedge clk);
    flushAllValid = 1'b1;
    fillValid = 1'b1; fillAsid = 4'd3; fillVpn = 8'h34; fillPfn = 8'hC4; fillPerm = 2'd1; fillPin = 1'b0;
    @(negedge clk);
    flushAllValid = 1'b0; fillValid = 1'b0;
    check("R9 dropped fill no err", int'(fillErr), 0);
    expectHit("R9 pinned survives", 1, 8'h31, 1, 8'hC1);
    expectHit("R9 unpinned flushed", 2, 8'h33, 0, 0);
    expectHit("R9 fill dropped", 3, 8'h34, 0, 0);
  endtask

  task automatic tAllPinned();
    int e;
    doReset();
    fill(1, 8'h41, 8'hD1, 1, 1, e);
    fill(1, 8'h42, 8'hD2, 1, 1, e);
    fill(1, 8'h43, 8'hD3, 1, 1, e);
    fill(1, 8'h44, 8'hD4, 1, 1, e);
    check("R10 no err while room", e, 0);
    fill(1, 8'h45, 8'hD5, 1, 0, e);
    check("R10 err raised", e, 1);
    @(negedge clk);
    check("R10 err one cycle", int'(fillErr), 0);
    expectHit("R10 refused fill absent", 1, 8'h45, 0, 0);
    expectHit("R10 contents kept", 1, 8'h41, 1, 8'hD1);
    expectHit("R10 contents kept", 1, 8'h44, 1, 8'hD4);
    fill(1, 8'h42, 8'hE2, 1, 1, e);
    check("R4 in-place no err", e, 0);
    expectHit("R4 overwritten frame", 1, 8'h42, 1, 8'hE2);
    expectHit("R4 neighbour kept", 1, 8'h43, 1, 8'hD3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    tReset();
    tBasic();
    tProtect();
    tRoundRobin();
    tPinned();
    tFlush();
    tAllPinned();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule